// File: doc/BRIEF.md
# General Purpose Register File with Return-Address Stack Window

This block holds the 32 general purpose registers of a small control-flow core. It has two read ports and one write port. Register 0 reads as zero and ignores writes. Registers 2 to 31 are plain flops. Register 1 has no storage of its own. Reading it takes the top entry from an external return-address stack, and writing it places a new entry there. The stack storage lives outside this block. It gives this block its top value and two flags: empty and full.

The file checks each valid instruction's use of register 1 against those flags. An instruction that pops an empty stack faults. An instruction that pushes onto a full stack without also popping faults. When an instruction faults, none of its effects are applied. The file then sets a sticky error output, and the error code reads 0x2. From then on it accepts no register writes and sends no stack requests until reset, so the core stays halted.

Top module: `gpr_stack_file`

## Requirements
- R1: A read of register 0 on either port returns 0, including after a write to register 0, and a write to register 0 causes no push.
- R2: A valid write to a register in 2..31 is visible to reads from the next cycle on; a read of that register in the same cycle returns the old value.
- R3: A valid instruction that reads register 1 on either enabled port raises `stack_pop_o` for that cycle, and the port returns `stack_top_i`.
- R4: When both enabled read ports select register 1 in one valid instruction, exactly one pop is issued and both ports return the same value.
- R5: A valid write to register 1 raises `stack_push_o` with `stack_push_data_o` equal to the write data, and it changes no storage register.
- R6: While `instr_valid_i` is low, neither pop nor push is issued and no register is written.
- R7: A valid read of register 1 while `stack_empty_i` is high is an underflow. It issues no pop and no push. From the next cycle `err_o` is 1 and `err_code_o` is 0x2.
- R8: A valid write of register 1 while `stack_full_i` is high is an overflow, unless the same instruction also reads register 1. On overflow no push is issued, and the error is raised on the next cycle as in R7.
- R9: A valid instruction that both reads and writes register 1 while the stack is full and not empty issues both a pop and a push, and raises no error.
- R10: A faulting instruction writes no register. Once `err_o` is set it stays set until reset, and no later instruction pushes, pops or writes a register.
- R11: After reset, every storage register reads 0, `err_o` is 0 and `err_code_o` is 0x0 (no error).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| instr_valid_i | input | 1 | The current instruction executes this cycle |
| rd_a_en_i | input | 1 | Read port A is used by the instruction |
| rd_a_addr_i | input | 5 | Read port A register index |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_en_i | input | 1 | Read port B is used by the instruction |
| rd_b_addr_i | input | 5 | Read port B register index |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | The instruction writes a register |
| wr_addr_i | input | 5 | Write register index |
| wr_data_i | input | 32 | Write data |
| stack_top_i | input | 32 | Top entry of the return-address stack |
| stack_empty_i | input | 1 | Stack holds no entry |
| stack_full_i | input | 1 | Stack holds its maximum number of entries |
| stack_pop_o | output | 1 | Remove the top entry this cycle |
| stack_push_o | output | 1 | Add an entry this cycle |
| stack_push_data_o | output | 32 | Entry to add |
| err_o | output | 1 | Sticky stack fault; the core halts |
| err_code_o | output | 32 | 0x0 for no error, 0x2 for a stack fault |

## Verification
The bench builds the block with its default parameters: 32 registers, 32-bit data and 32-bit error codes. At that size the boundary registers 2 and 31 can be reached directly. The stack flags are driven from the bench, so both stack boundaries can be forced in any cycle: empty for underflow, and full for overflow and for the pop-then-push case. The sticky halt is checked after each fault and then released by reset.

// File: rtl/gpr_stack_pkg.sv
package gpr_stack_pkg;
  localparam int unsigned NumRegs = 32;
  localparam int unsigned DataW   = 32;
  localparam int unsigned ErrW    = 32;
  localparam int unsigned AddrW   = $clog2(NumRegs);

  localparam logic [AddrW-1:0] ZeroIdx  = AddrW'(0);
  localparam logic [AddrW-1:0] StackIdx = AddrW'(1);

  typedef enum logic [ErrW-1:0] {
    ErrNone      = ErrW'(32'h0),
    ErrBadAddr   = ErrW'(32'h1),
    ErrStackFlow = ErrW'(32'h2)
  } err_code_e;
endpackage

// File: rtl/gpr_storage.sv
module gpr_storage #(
  parameter int unsigned NumRegs = 32,
  parameter int unsigned DataW   = 32,
  localparam int unsigned AddrW  = $clog2(NumRegs)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AddrW-1:0] waddr_i,
  input  logic [DataW-1:0] wdata_i,
  input  logic [AddrW-1:0] raddr_a_i,
  input  logic [AddrW-1:0] raddr_b_i,
  output logic [DataW-1:0] rdata_a_o,
  output logic [DataW-1:0] rdata_b_o
);
  logic [DataW-1:0] regs_q [NumRegs];

  // Indices 0 and 1 hold no state
  assign regs_q[0] = '0;
  assign regs_q[1] = '0;

  for (genvar i = 2; i < NumRegs; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          regs_q[i] <= '0;
      else if (we_i && waddr_i == AddrW'(i)) regs_q[i] <= wdata_i;
    end
  end

  assign rdata_a_o = regs_q[raddr_a_i];
  assign rdata_b_o = regs_q[raddr_b_i];

  // R2: storage index 0/1 is never a write target
  a_r2_no_low_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> (waddr_i > AddrW'(1)));
endmodule

// File: rtl/gpr_stack_ctrl.sv
module gpr_stack_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic halted_i,
  input  logic rd_a_x1_i,
  input  logic rd_b_x1_i,
  input  logic wr_x1_i,
  input  logic empty_i,
  input  logic full_i,
  output logic pop_o,
  output logic push_o,
  output logic fault_o,
  output logic commit_o
);
  logic live, want_pop, want_push, underflow, overflow;

  assign live      = valid_i && !halted_i;
  // Dual x1 reads collapse into one pop
  assign want_pop  = live && (rd_a_x1_i || rd_b_x1_i);
  assign want_push = live && wr_x1_i;
  assign underflow = want_pop && empty_i;
  // Pop is ordered before push, so a full stack with a pop has room
  assign overflow  = want_push && full_i && !want_pop;
  assign fault_o   = underflow || overflow;
  assign commit_o  = live && !fault_o;
  assign pop_o     = want_pop && commit_o;
  assign push_o    = want_push && commit_o;

  a_r7_no_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |-> !empty_i);
  a_r8_push_full_needs_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && full_i) |-> pop_o);
  a_r6_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (!pop_o && !push_o));
  a_r3_pop_has_reader: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |-> (rd_a_x1_i || rd_b_x1_i));
endmodule

// File: rtl/gpr_err_track.sv
module gpr_err_track
  import gpr_stack_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fault_i,
  output logic            halted_o,
  output logic [ErrW-1:0] err_code_o
);
  logic err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      err_q <= 1'b0;
    else if (fault_i) err_q <= 1'b1;
  end

  assign halted_o   = err_q;
  assign err_code_o = err_q ? ErrStackFlow : ErrNone;

  a_r10_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
  a_r7_set_after_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |=> (err_code_o == ErrStackFlow));
endmodule

// File: rtl/gpr_stack_file.sv
module gpr_stack_file
  import gpr_stack_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              instr_valid_i,
  input  logic              rd_a_en_i,
  input  logic [AddrW-1:0]  rd_a_addr_i,
  output logic [DataW-1:0]  rd_a_data_o,
  input  logic              rd_b_en_i,
  input  logic [AddrW-1:0]  rd_b_addr_i,
  output logic [DataW-1:0]  rd_b_data_o,
  input  logic              wr_en_i,
  input  logic [AddrW-1:0]  wr_addr_i,
  input  logic [DataW-1:0]  wr_data_i,
  input  logic [DataW-1:0]  stack_top_i,
  input  logic              stack_empty_i,
  input  logic              stack_full_i,
  output logic              stack_pop_o,
  output logic              stack_push_o,
  output logic [DataW-1:0]  stack_push_data_o,
  output logic              err_o,
  output logic [ErrW-1:0]   err_code_o
);
  logic rd_a_x1, rd_b_x1, wr_x1, halted, fault, commit, store_we;
  logic [DataW-1:0] st_a, st_b;

  assign rd_a_x1 = rd_a_en_i && rd_a_addr_i == StackIdx;
  assign rd_b_x1 = rd_b_en_i && rd_b_addr_i == StackIdx;
  assign wr_x1   = wr_en_i && wr_addr_i == StackIdx;

  gpr_stack_ctrl u_ctrl (
    .clk_i, .rst_ni,
    .valid_i   (instr_valid_i),
    .halted_i  (halted),
    .rd_a_x1_i (rd_a_x1),
    .rd_b_x1_i (rd_b_x1),
    .wr_x1_i   (wr_x1),
    .empty_i   (stack_empty_i),
    .full_i    (stack_full_i),
    .pop_o     (stack_pop_o),
    .push_o    (stack_push_o),
    .fault_o   (fault),
    .commit_o  (commit)
  );

  gpr_err_track u_err (
    .clk_i, .rst_ni,
    .fault_i    (fault),
    .halted_o   (halted),
    .err_code_o (err_code_o)
  );

  assign store_we = commit && wr_en_i && wr_addr_i > StackIdx;

  gpr_storage #(.NumRegs(NumRegs), .DataW(DataW)) u_store (
    .clk_i, .rst_ni,
    .we_i      (store_we),
    .waddr_i   (wr_addr_i),
    .wdata_i   (wr_data_i),
    .raddr_a_i (rd_a_addr_i),
    .raddr_b_i (rd_b_addr_i),
    .rdata_a_o (st_a),
    .rdata_b_o (st_b)
  );

  always_comb begin
    unique case (rd_a_addr_i)
      ZeroIdx:  rd_a_data_o = '0;
      StackIdx: rd_a_data_o = stack_top_i;
      default:  rd_a_data_o = st_a;
    endcase
    unique case (rd_b_addr_i)
      ZeroIdx:  rd_b_data_o = '0;
      StackIdx: rd_b_data_o = stack_top_i;
      default:  rd_b_data_o = st_b;
    endcase
  end

  assign stack_push_data_o = wr_data_i;
  assign err_o             = halted;

  a_r10_halt_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!stack_pop_o && !stack_push_o));
  a_r4_same_pop_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stack_pop_o && rd_a_x1 && rd_b_x1) |-> (rd_a_data_o == rd_b_data_o));
  a_r11_code_matches_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_code_o == ErrNone) == !err_o);
  a_r1_push_only_x1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stack_push_o |-> wr_x1);
endmodule

// File: tb/gpr_stack_file_bench.sv
module gpr_stack_file_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        valid, a_en, b_en, we, empty, full;
  logic [4:0]  a_addr, b_addr, w_addr;
  logic [31:0] w_data, top;
  logic [31:0] a_data, b_data, push_data, err_code;
  logic        pop, push, err;

  gpr_stack_file u_gpr_stack_file (
    .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(valid),
    .rd_a_en_i(a_en), .rd_a_addr_i(a_addr), .rd_a_data_o(a_data),
    .rd_b_en_i(b_en), .rd_b_addr_i(b_addr), .rd_b_data_o(b_data),
    .wr_en_i(we), .wr_addr_i(w_addr), .wr_data_i(w_data),
    .stack_top_i(top), .stack_empty_i(empty), .stack_full_i(full),
    .stack_pop_o(pop), .stack_push_o(push), .stack_push_data_o(push_data),
    .err_o(err), .err_code_o(err_code)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic        v;  logic ae; logic [4:0] aa; logic be; logic [4:0] ba;
    logic        we; logic [4:0] wa; logic [31:0] wd;
    logic        em; logic fu; logic [31:0] tp;
    logic [31:0] ea; logic [31:0] eb; logic ep; logic eu;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    // R2: same-cycle read sees old value
    '{1'b1,1'b1,5'd5, 1'b0,5'd0, 1'b1,5'd5, 32'hA5A5_0001, 1'b0,1'b0,32'h0, 32'h0,32'h0, 1'b0,1'b0},
    // R2: next cycle sees new value; R1 port B x0
    '{1'b1,1'b1,5'd5, 1'b1,5'd0, 1'b0,5'd0, 32'h0, 1'b0,1'b0,32'h0, 32'hA5A5_0001,32'h0, 1'b0,1'b0},
    // R1: write to x0, no push
    '{1'b1,1'b1,5'd0, 1'b0,5'd0, 1'b1,5'd0, 32'hFFFF_FFFF, 1'b0,1'b0,32'h0, 32'h0,32'h0, 1'b0,1'b0},
    // R1: x0 still zero; R11 x31 at reset value
    '{1'b1,1'b1,5'd31, 1'b1,5'd0, 1'b0,5'd0, 32'h0, 1'b0,1'b0,32'h0, 32'h0,32'h0, 1'b0,1'b0},
    // R6: invalid instruction write ignored
    '{1'b0,1'b0,5'd0, 1'b0,5'd0, 1'b1,5'd31, 32'h0000_1234, 1'b0,1'b0,32'h0, 32'h0,32'h0, 1'b0,1'b0},
    // R6 readback, R3 pop on port B
    '{1'b1,1'b1,5'd31, 1'b1,5'd1, 1'b0,5'd0, 32'h0, 1'b0,1'b0,32'hCAFE_0000, 32'h0,32'hCAFE_0000, 1'b1,1'b0},
    // R4: both ports x1, one pop
    '{1'b1,1'b1,5'd1, 1'b1,5'd1, 1'b0,5'd0, 32'h0, 1'b0,1'b0,32'h0000_0077, 32'h77,32'h77, 1'b1,1'b0},
    // R5: push of x1 write
    '{1'b1,1'b0,5'd0, 1'b0,5'd0, 1'b1,5'd1, 32'h0000_1111, 1'b0,1'b0,32'h0, 32'h0,32'h0, 1'b0,1'b1},
    // R6: invalid x1 read/write issues nothing
    '{1'b0,1'b1,5'd1, 1'b0,5'd0, 1'b1,5'd1, 32'h0000_2222, 1'b0,1'b0,32'h5, 32'h5,32'h0, 1'b0,1'b0},
    // R9: full stack, read and write x1 allowed
    '{1'b1,1'b1,5'd1, 1'b0,5'd0, 1'b1,5'd1, 32'h0000_3333, 1'b0,1'b1,32'h9, 32'h9,32'h0, 1'b1,1'b1}
  };

  task automatic idle();
    valid = 0; a_en = 0; b_en = 0; we = 0; empty = 0; full = 0;
    a_addr = 0; b_addr = 0; w_addr = 0; w_data = 0; top = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); idle(); rst_n = 0;
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (2) @(negedge clk);
    rst_n = 1;
    #1;
    chk({31'h0, err}, 32'h0, "R11 err after reset");
    chk(err_code, 32'h0, "R11 code after reset");

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      valid = TBL[i].v; a_en = TBL[i].ae; a_addr = TBL[i].aa;
      b_en = TBL[i].be; b_addr = TBL[i].ba; we = TBL[i].we;
      w_addr = TBL[i].wa; w_data = TBL[i].wd; empty = TBL[i].em;
      full = TBL[i].fu; top = TBL[i].tp;
      #2;
      chk(a_data, TBL[i].ea, $sformatf("R1/R2/R3 vec %0d port A", i));
      chk(b_data, TBL[i].eb, $sformatf("R4 vec %0d port B", i));
      chk({31'h0, pop}, {31'h0, TBL[i].ep}, $sformatf("R3/R6 vec %0d pop", i));
      chk({31'h0, push}, {31'h0, TBL[i].eu}, $sformatf("R5/R6 vec %0d push", i));
      if (TBL[i].eu) chk(push_data, TBL[i].wd, $sformatf("R5 vec %0d push data", i));
      chk({31'h0, err}, 32'h0, $sformatf("R9 vec %0d no error", i));
    end

    // R5: x1 write left storage untouched, x2 still zero
    @(negedge clk); idle(); valid = 1; a_en = 1; a_addr = 5'd2; #2;
    chk(a_data, 32'h0, "R5 no storage change");
    // R2: boundary register 2
    @(negedge clk); idle(); valid = 1; we = 1; w_addr = 5'd2; w_data = 32'hBEEF_0002;
    @(negedge clk); idle(); a_addr = 5'd2; #2;
    chk(a_data, 32'hBEEF_0002, "R2 reg2 write");

    // R7: underflow
    @(negedge clk); idle(); valid = 1; a_en = 1; a_addr = 5'd1; empty = 1;
    we = 1; w_addr = 5'd3; w_data = 32'h0000_00AB; #2;
    chk({31'h0, pop}, 32'h0, "R7 no pop on empty");
    @(negedge clk); idle(); b_addr = 5'd3; #1;
    chk({31'h0, err}, 32'h1, "R7 err set");
    chk(err_code, 32'h2, "R7 code 0x2");
    chk(b_data, 32'h0, "R10 faulting write dropped");
    // R10: halted, nothing issues
    @(negedge clk); valid = 1; we = 1; w_addr = 5'd1; w_data = 32'h1; a_en = 1; a_addr = 5'd1; #2;
    chk({30'h0, pop, push}, 32'h0, "R10 halted no stack req");
    @(negedge clk); idle(); valid = 1; we = 1; w_addr = 5'd4; w_data = 32'h44;
    @(negedge clk); idle(); a_addr = 5'd4; #1;
    chk(a_data, 32'h0, "R10 halted no write");
    chk({31'h0, err}, 32'h1, "R10 err sticky");

    // R11: reset clears error and storage
    do_reset(); #1;
    chk({31'h0, err}, 32'h0, "R11 err cleared");
    chk(err_code, 32'h0, "R11 code cleared");
    a_addr = 5'd5; b_addr = 5'd2; #1;
    chk(a_data, 32'h0, "R11 reg5 cleared");
    chk(b_data, 32'h0, "R11 reg2 cleared");

    // R8: overflow
    @(negedge clk); idle(); valid = 1; we = 1; w_addr = 5'd1; w_data = 32'h55; full = 1; #2;
    chk({31'h0, push}, 32'h0, "R8 no push on full");
    @(negedge clk); idle(); #1;
    chk(err_code, 32'h2, "R8 code 0x2");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule